// File: doc/BRIEF.md
# Indirect Management Register Bridge

This block sits behind a decoded management-bus slave and gives a host access to an internal space of 32 devices with 32 sixteen-bit registers each. Each incoming transaction carries a bus address, a register number, a direction and write data. A 5-bit strap input picks one of two operating modes.

With the strap at zero, the bridge claims every bus address. A transaction to bus address N, register M becomes an access to internal device N, register M. With a nonzero strap, the bridge answers only its own address and presents two registers there: a command register at register 0 and a data register at register 1. Writing the command register with the go bit set starts an internal read or write. The device and register are taken from the command. The bridge runs the internal access over a fixed latency of `ACC_LAT` cycles and holds the go bit high until that access finishes.

The internal side is a plain register-file port. It carries device, register, write data and one-cycle write and read strobes. Read data is sampled `ACC_LAT` cycles after the strobe cycle begins.

Top module: `mgmt_bridge`

## Requirements
- R1: After reset, no response is pending, no internal strobe is active, and both the command register and the data register read as 0x0000.
- R2: With strap 0, a request to bus address P, register M starts an internal access to device P, register M. A read produces `rsp_valid` with the internal data one cycle after the capture edge. A write produces no response.
- R3: With strap 0, a request that arrives while an internal access is still in flight is ignored. This includes a request on the edge where that access completes.
- R4: With a nonzero strap, requests to any other bus address cause no strobe, no response and no change of bridge state.
- R5: In indirect mode, a read of the bridge's own address returns one cycle later. Register 0 returns bit 15 = busy and bits 14:0 as last stored. Register 1 returns the data register. Any other register returns 0.
- R6: A command write with bit 15 set and bits 14:10 = 00110 (for example 0x9800) reads internal device bits 9:5, register bits 4:0, and places the result in the data register.
- R7: A command write with bit 15 set and bits 14:10 = 00101 (for example 0x9400) writes the current data register value to internal device bits 9:5, register bits 4:0.
- R8: Busy reads as one from the cycle after a command is accepted for exactly `ACC_LAT` cycles.
- R9: A command write with bit 15 set and any other value in bits 14:10 produces no internal strobe, and busy reads as zero afterwards.
- R10: Writes to the command or data register while busy is set are ignored.
- R11: The internal read and write strobes are single-cycle pulses and never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | 5 | Strapped bus address; zero selects direct mode |
| req_valid | input | 1 | Decoded transaction present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Bus address of the transaction |
| req_reg | input | 5 | Register number of the transaction |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| int_dev | output | 5 | Internal device address |
| int_reg | output | 5 | Internal register address |
| int_wdata | output | 16 | Internal write data |
| int_we | output | 1 | Internal write strobe |
| int_re | output | 1 | Internal read strobe |
| int_rdata | input | 16 | Internal read data, sampled `ACC_LAT` cycles after the strobe |

## Verification
The bench builds the bridge with `ACC_LAT` = 3. This makes the busy window long enough to poll the command register several times per operation and to collide command and data writes with it. It also places a new request exactly on the completion edge. The strap is a bench signal, so one instance covers direct mode and indirect mode (strap 5), including foreign-address traffic. Internal storage is a bench-side 1024-entry array read combinationally through `int_dev`/`int_reg`.

// File: rtl/mgmt_bridge_pkg.sv
package mgmt_bridge_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int OP_LSB = 10;
  localparam int GO_BIT = 15;
  localparam logic [4:0] OP_RD = 5'b00110;
  localparam logic [4:0] OP_WR = 5'b00101;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] dev;
    logic [ADDR_W-1:0] regn;
    logic [DATA_W-1:0] wdata;
  } acc_req_t;
endpackage

// File: rtl/acc_engine.sv
module acc_engine
  import mgmt_bridge_pkg::*;
#(
  parameter int ACC_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  acc_req_t          req,
  input  logic [DATA_W-1:0] int_rdata,
  output logic              active,
  output logic              done_rd,
  output logic [DATA_W-1:0] cap_data,
  output logic [ADDR_W-1:0] int_dev,
  output logic [ADDR_W-1:0] int_reg,
  output logic [DATA_W-1:0] int_wdata,
  output logic              int_we,
  output logic              int_re
);
  localparam int CNT_W = (ACC_LAT < 2) ? 1 : $clog2(ACC_LAT);

  logic [CNT_W-1:0] cnt_q;
  logic             rd_q;

  assign done_rd  = active && (cnt_q == '0) && rd_q;
  assign cap_data = int_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      cnt_q     <= '0;
      rd_q      <= 1'b0;
      int_dev   <= '0;
      int_reg   <= '0;
      int_wdata <= '0;
      int_we    <= 1'b0;
      int_re    <= 1'b0;
    end else begin
      int_we <= 1'b0;
      int_re <= 1'b0;
      if (start) begin
        active    <= 1'b1;
        cnt_q     <= CNT_W'(ACC_LAT - 1);
        rd_q      <= !req.wr;
        int_dev   <= req.dev;
        int_reg   <= req.regn;
        int_wdata <= req.wdata;
        int_we    <= req.wr;
        int_re    <= !req.wr;
      end else if (active) begin
        if (cnt_q == '0) active <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assert_start_idle_R3: assert property (@(posedge clk) disable iff (rst)
    start |-> !active);
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(int_we && int_re));
  assert_strobe_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (int_we || int_re) |=> !(int_we || int_re));
endmodule

// File: rtl/ind_regs.sv
module ind_regs
  import mgmt_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              busy,
  input  logic              done_rd,
  input  logic [DATA_W-1:0] cap_data,
  output logic              start,
  output acc_req_t          req,
  output logic [DATA_W-1:0] rd_val
);
  logic [DATA_W-2:0] cmd_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_ok;
  logic [4:0]        op;

  assign wr_ok = sel && req_write && !busy;
  assign op    = req_wdata[OP_LSB +: 5];
  assign start = wr_ok && (req_reg == 5'd0) && req_wdata[GO_BIT]
                 && ((op == OP_RD) || (op == OP_WR));

  always_comb begin
    req.wr    = (op == OP_WR);
    req.dev   = req_wdata[2*ADDR_W-1:ADDR_W];
    req.regn  = req_wdata[ADDR_W-1:0];
    req.wdata = data_q;
  end

  always_comb begin
    case (req_reg)
      5'd0:    rd_val = {busy, cmd_q};
      5'd1:    rd_val = data_q;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_ok && req_reg == 5'd0) cmd_q <= req_wdata[DATA_W-2:0];
      if (wr_ok && req_reg == 5'd1) data_q <= req_wdata;
      else if (done_rd)             data_q <= cap_data;
    end
  end

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (sel && req_write && busy) |=> $stable(cmd_q));
endmodule

// File: rtl/mgmt_bridge.sv
module mgmt_bridge
  import mgmt_bridge_pkg::*;
#(
  parameter int ACC_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        strap_addr,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [4:0]        req_phy,
  input  logic [4:0]        req_reg,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [4:0]        int_dev,
  output logic [4:0]        int_reg,
  output logic [15:0]       int_wdata,
  output logic              int_we,
  output logic              int_re,
  input  logic [15:0]       int_rdata
);
  logic              direct;
  logic              dsel, isel;
  logic              eng_active, eng_done_rd, eng_start;
  logic [DATA_W-1:0] cap_data, ind_rd;
  logic              ind_start;
  acc_req_t          ind_req, dir_req, eng_req;

  assign direct = (strap_addr == '0);
  assign dsel   = req_valid && direct && !eng_active;
  assign isel   = req_valid && !direct && (req_phy == strap_addr);

  always_comb begin
    dir_req.wr    = req_write;
    dir_req.dev   = req_phy;
    dir_req.regn  = req_reg;
    dir_req.wdata = req_wdata;
  end

  assign eng_start = dsel || ind_start;
  assign eng_req   = direct ? dir_req : ind_req;

  acc_engine #(.ACC_LAT(ACC_LAT)) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .req(eng_req),
    .int_rdata(int_rdata), .active(eng_active), .done_rd(eng_done_rd),
    .cap_data(cap_data), .int_dev(int_dev), .int_reg(int_reg),
    .int_wdata(int_wdata), .int_we(int_we), .int_re(int_re)
  );

  ind_regs u_regs (
    .clk(clk), .rst(rst), .sel(isel), .req_write(req_write),
    .req_reg(req_reg), .req_wdata(req_wdata), .busy(eng_active),
    .done_rd(eng_done_rd && !direct), .cap_data(cap_data),
    .start(ind_start), .req(ind_req), .rd_val(ind_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (direct && eng_done_rd) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= cap_data;
      end else if (isel && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= ind_rd;
      end
    end
  end

  assert_foreign_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !direct && req_phy != strap_addr && !eng_active)
      |=> !(int_we || int_re || rsp_valid));
  assert_bad_op_R9: assert property (@(posedge clk) disable iff (rst)
    (isel && req_write && req_reg == 5'd0 && req_wdata[GO_BIT]
     && req_wdata[14:10] != OP_RD && req_wdata[14:10] != OP_WR)
      |=> !(int_we || int_re));
endmodule

// File: tb/sim_mgmt_bridge.sv
module sim_mgmt_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic clk = 0, rst = 1;
  logic [4:0] strap_addr = 0;
  logic req_valid = 0, req_write = 0;
  logic [4:0] req_phy = 0, req_reg = 0;
  logic [15:0] req_wdata = 0;
  logic rsp_valid, int_we, int_re;
  logic [15:0] rsp_rdata, int_wdata, int_rdata;
  logic [4:0] int_dev, int_reg;

  logic [15:0] mem [1024];
  int checks = 0, errors = 0, cyc = 0;
  string cur = "R1";
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_bridge #(.ACC_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .strap_addr(strap_addr), .req_valid(req_valid),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .int_dev(int_dev), .int_reg(int_reg), .int_wdata(int_wdata),
    .int_we(int_we), .int_re(int_re), .int_rdata(int_rdata));

  assign int_rdata = mem[{int_dev, int_reg}];

  // behavioural reference model
  bit m_act, m_rd, m_direct;
  int m_cnt;
  int m_dev, m_reg;
  logic [14:0] m_cmd;
  logic [15:0] m_data;
  bit e_rv, e_we, e_re;
  logic [15:0] e_rd, e_wd;
  int e_dev, e_reg;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_act = 0; m_cnt = 0; m_cmd = 0; m_data = 0;
      e_rv = 0; e_we = 0; e_re = 0;
    end else begin
      bit busy_old;
      logic [15:0] data_old;
      bit nrv, nwe, nre;
      logic [15:0] nrd;
      nrv = 0; nwe = 0; nre = 0; nrd = 0;
      if (e_we) mem[e_dev*32 + e_reg] = e_wd;
      busy_old = m_act;
      data_old = m_data;
      if (m_act) begin
        if (m_cnt == 0) begin
          m_act = 0;
          if (m_rd) begin
            if (m_direct) begin nrv = 1; nrd = mem[m_dev*32 + m_reg]; end
            else m_data = mem[m_dev*32 + m_reg];
          end
        end else m_cnt--;
      end
      if (req_valid) begin
        if (strap_addr == 0) begin
          if (!busy_old) begin
            m_act = 1; m_cnt = LAT-1; m_rd = !req_write; m_direct = 1;
            m_dev = req_phy; m_reg = req_reg;
            nwe = req_write; nre = !req_write;
            e_wd = req_wdata;
          end
        end else if (req_phy == strap_addr) begin
          if (!req_write) begin
            nrv = 1;
            nrd = (req_reg == 0) ? {busy_old, m_cmd} : (req_reg == 1) ? data_old : 16'h0;
          end else if (!busy_old) begin
            if (req_reg == 0) begin
              m_cmd = req_wdata[14:0];
              if (req_wdata[15] && (req_wdata[14:10] == 5'b00110 || req_wdata[14:10] == 5'b00101)) begin
                m_act = 1; m_cnt = LAT-1; m_direct = 0;
                m_rd = (req_wdata[14:10] == 5'b00110);
                m_dev = req_wdata[9:5]; m_reg = req_wdata[4:0];
                nwe = !m_rd; nre = m_rd; e_wd = data_old;
              end
            end else if (req_reg == 1) m_data = req_wdata;
          end
        end
      end
      e_rv = nrv; e_rd = nrd; e_we = nwe; e_re = nre;
      e_dev = m_dev; e_reg = m_reg;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      check(rsp_valid == e_rv, {cur, " rsp_valid"}, rsp_valid, e_rv);
      if (e_rv) check(rsp_rdata == e_rd, {cur, " rsp_rdata"}, rsp_rdata, e_rd);
      check(int_we == e_we, {cur, " int_we"}, int_we, e_we);
      check(int_re == e_re, {cur, " int_re"}, int_re, e_re);
      check(!(int_we && int_re), "R11 strobes", {int_we, int_re}, 0);
      if (e_we || e_re) begin
        check(int_dev == e_dev[4:0], {cur, " int_dev"}, int_dev, e_dev);
        check(int_reg == e_reg[4:0], {cur, " int_reg"}, int_reg, e_reg);
      end
      if (e_we) check(int_wdata == e_wd, {cur, " int_wdata"}, int_wdata, e_wd);
    end
  end

  task automatic bus(input bit w, input int phy, input int r, input int d);
    req_valid = 1; req_write = w; req_phy = phy[4:0]; req_reg = r[4:0];
    req_wdata = d[15:0];
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 7 + 3);
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check(rsp_valid == 0 && int_we == 0 && int_re == 0, "R1 outputs", {rsp_valid, int_we, int_re}, 0);
    strap_addr = 5'd5;
    idle(1);
    bus(0, 5, 0, 0); idle(1);
    bus(0, 5, 1, 0); idle(2);

    cur = "R2"; strap_addr = 0; idle(1);
    bus(1, 3, 7, 16'h1234); idle(LAT + 2);
    bus(0, 3, 7, 0);        idle(LAT + 2);
    bus(1, 31, 31, 16'hA5C3); idle(LAT + 2);
    bus(0, 31, 31, 0);      idle(LAT + 2);
    bus(0, 0, 0, 0);        idle(LAT + 2);

    cur = "R3";
    bus(1, 4, 2, 16'h1111); bus(1, 4, 3, 16'h2222); idle(LAT - 2);
    bus(0, 4, 3, 0);        idle(LAT + 2);
    bus(0, 4, 2, 0);        idle(LAT + 2);

    cur = "R4"; strap_addr = 5'd5; idle(1);
    bus(1, 3, 0, 16'h9800); idle(2);
    bus(0, 3, 1, 0);        idle(2);
    bus(1, 0, 1, 16'hFFFF); idle(2);

    cur = "R5";
    bus(0, 5, 0, 0); bus(0, 5, 1, 0); bus(0, 5, 7, 0); idle(2);

    cur = "R7";
    bus(1, 5, 1, 16'hBEEF);
    bus(1, 5, 0, 16'h9400 | (9 << 5) | 4);
    cur = "R8";
    for (int k = 0; k < LAT + 2; k++) bus(0, 5, 0, 0);

    cur = "R6";
    bus(1, 5, 1, 16'h0000);
    bus(1, 5, 0, 16'h9800 | (9 << 5) | 4);
    cur = "R10";
    bus(1, 5, 1, 16'h7777);
    bus(1, 5, 0, 16'h9400 | (1 << 5) | 1);
    idle(LAT);
    cur = "R6";
    bus(0, 5, 1, 0); bus(0, 5, 0, 0); idle(2);
    bus(1, 5, 0, 16'h9800 | (31 << 5) | 30);
    idle(LAT - 1);
    bus(0, 5, 1, 0);
    bus(0, 5, 1, 0); idle(2);

    cur = "R9";
    bus(1, 5, 0, 16'h8000 | (3 << 10) | 16'h0042);
    bus(0, 5, 0, 0);
    bus(1, 5, 0, 16'hFC00);
    bus(0, 5, 0, 0); idle(3);

    cur = "R2";
    strap_addr = 0; idle(1);
    bus(0, 9, 4, 0); idle(LAT + 2);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule